// File: doc/BRIEF.md
# GPIO Bank Register File

This block is the register file of a bank of general-purpose pins (94 by default). A 32-bit register bus with a write strobe, a read strobe and a byte address reaches two kinds of storage. The first kind is bitmapped words, 32 pins per word. They hold a pin-ownership map that boot firmware loads. The second kind is a pair of configuration words for every pin. They hold the driven level, the direction, the use select, the trigger kind and polarity, the input-sensing disable and the weak-pull choice.

The block drives each pad's output level and output enable. It passes each pad input through a two-flop synchronizer. It reports the sensed level both in a read-only configuration bit and on a per-pin output that a separate interrupt block consumes. That interrupt block also receives each pin's trigger settings and the bank-wide choice between system interrupt line 14 and line 15. Pad electrical behaviour, pull strength and native functions stay outside the block. It only stores and exports the use-select and pull fields.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every pin's first config word reads 0x0000_0005 (input, GPIO use, level 0). Every second config word reads 0x0000_0004 (sensing disabled). Each ownership word reads 1 for every existing pin, so the last word reads 0x3FFF_FFFF with 94 pins. The line select reads 0.
- R2: Pin p's ownership bit is bit p%32 of the word at byte offset (p/32)*4. A 1 means the pin is free for GPIO use and a 0 means it is reserved for firmware. `owner_o[p]` follows the stored bit. Bits of nonexistent pins read 0.
- R3: Pin p's first config word is at 0x100+8p and its second is at 0x104+8p. The first word stores bit 31 (output level), bit 4 (1 = level trigger), bit 3 (invert polarity), bit 2 (1 = input) and bit 0 (1 = GPIO use). The second word stores bit 2 (sensing disable) and bits 1:0 (pull option). All other bits read 0.
- R4: `gpio_o[p]` equals the stored output level. `gpio_oe_o[p]` is 1 only when use is GPIO and direction is output.
- R5: Bit 30 of the first word is read-only and ignores writes. While sensing is enabled, it reads the synchronized pad level.
- R6: While sensing is disabled, bit 30 and `sense_o[p]` read 0 whatever the pad does.
- R7: A pad change reaches `sense_o` at the second rising clock edge after it is applied, through two flops.
- R8: `trig_level_o`, `trig_inv_o`, `use_gpio_o`, `sense_en_o` and `pull_o[2p+1:2p]` export the stored fields of each pin.
- R9: Bit 0 of the word at 0x7C is the line select (0 = line 14, 1 = line 15) and is driven on `irq_line_sel_o`. Its other bits read 0.
- R10: Reads of unmapped or unaligned offsets, including per-pin words of pins 94 and above, return 0. Writes to them change nothing.
- R11: `rdata_o` is registered. It takes the addressed word at the edge where `rd_en_i` is sampled high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_i | input | 94 | Pad input levels, asynchronous |
| gpio_o | output | 94 | Driven output levels |
| gpio_oe_o | output | 94 | Pad output enables |
| owner_o | output | 94 | Ownership map, 1 = GPIO may be used |
| use_gpio_o | output | 94 | Use select, 1 = GPIO |
| sense_en_o | output | 94 | Input sensing enabled |
| sense_o | output | 94 | Synchronized, gated input levels |
| trig_level_o | output | 94 | Trigger kind, 1 = level |
| trig_inv_o | output | 94 | Trigger polarity invert |
| pull_o | output | 188 | Pull option, two bits per pin |
| irq_line_sel_o | output | 1 | 0 = line 14, 1 = line 15 |

## Verification
A wrong stored field shows up on its exported pin output at the next clock after the write. It shows up in `rdata_o` one cycle after a read of that word. An address decoding fault puts data in the wrong pin's outputs or in a readback that should be zero. The bench therefore tests pins at the first, a middle and the last index, and it reads back across word boundaries. A fault in the sensing gate or the synchronizer shows up on `sense_o` either too early, too late or while sensing is disabled. The bench samples it at each of the two edges that follow a pad change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned C1_OUT   = 31;
  localparam int unsigned C1_IN    = 30;
  localparam int unsigned C1_TRIG  = 4;
  localparam int unsigned C1_INV   = 3;
  localparam int unsigned C1_DIR   = 2;
  localparam int unsigned C1_USE   = 0;
  localparam int unsigned C2_SDIS  = 2;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_level;
    logic       trig_inv;
    logic       dir_in;
    logic       use_gpio;
    logic       sense_dis;
    logic [1:0] pull;
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RST = '{
    out_lvl: 1'b0, trig_level: 1'b0, trig_inv: 1'b0, dir_in: 1'b1,
    use_gpio: 1'b1, sense_dis: 1'b1, pull: 2'b00};
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 94
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_c1_i,
  input  logic              wr_c2_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              in_sync_i,
  output logic [DATA_W-1:0] cfg1_rd_o,
  output logic [DATA_W-1:0] cfg2_rd_o,
  output pin_cfg_t          cfg_o,
  output logic              sense_o
);
  pin_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= PIN_CFG_RST;
    end else begin
      if (wr_c1_i) begin
        cfg_q.out_lvl    <= wdata_i[C1_OUT];
        cfg_q.trig_level <= wdata_i[C1_TRIG];
        cfg_q.trig_inv   <= wdata_i[C1_INV];
        cfg_q.dir_in     <= wdata_i[C1_DIR];
        cfg_q.use_gpio   <= wdata_i[C1_USE];
      end
      if (wr_c2_i) begin
        cfg_q.sense_dis <= wdata_i[C2_SDIS];
        cfg_q.pull      <= wdata_i[1:0];
      end
    end
  end

  assign sense_o = in_sync_i & ~cfg_q.sense_dis;
  assign cfg_o   = cfg_q;

  always_comb begin
    cfg1_rd_o          = '0;
    cfg1_rd_o[C1_OUT]  = cfg_q.out_lvl;
    cfg1_rd_o[C1_IN]   = sense_o;
    cfg1_rd_o[C1_TRIG] = cfg_q.trig_level;
    cfg1_rd_o[C1_INV]  = cfg_q.trig_inv;
    cfg1_rd_o[C1_DIR]  = cfg_q.dir_in;
    cfg1_rd_o[C1_USE]  = cfg_q.use_gpio;
    cfg2_rd_o          = '0;
    cfg2_rd_o[C2_SDIS] = cfg_q.sense_dis;
    cfg2_rd_o[1:0]     = cfg_q.pull;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 94,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   pad_i,
  output logic [NUM_PINS-1:0]   gpio_o,
  output logic [NUM_PINS-1:0]   gpio_oe_o,
  output logic [NUM_PINS-1:0]   owner_o,
  output logic [NUM_PINS-1:0]   use_gpio_o,
  output logic [NUM_PINS-1:0]   sense_en_o,
  output logic [NUM_PINS-1:0]   sense_o,
  output logic [NUM_PINS-1:0]   trig_level_o,
  output logic [NUM_PINS-1:0]   trig_inv_o,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic                  irq_line_sel_o
);
  localparam int unsigned NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int unsigned PSEL_W    = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(12'h07C);
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] CFG_END  = ADDR_W'(256 + 8 * NUM_PINS);
  localparam logic [ADDR_W-1:0] BM_END   = ADDR_W'(4 * NUM_WORDS);

  // address decode
  logic              aligned, bm_hit, ctrl_hit, cfg_hit;
  logic [ADDR_W-1:0] cfg_off;
  logic [PSEL_W-1:0] pin_sel;
  logic [WIDX_W-1:0] word_sel;
  logic [PIN_W-1:0]  pin_idx;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign bm_hit   = aligned && (addr_i < BM_END);
  assign ctrl_hit = (addr_i == CTRL_OFF);
  assign cfg_hit  = aligned && (addr_i >= CFG_BASE) && (addr_i < CFG_END);
  assign cfg_off  = addr_i - CFG_BASE;
  assign pin_sel  = cfg_off[ADDR_W-1:3];
  assign pin_idx  = pin_sel[PIN_W-1:0];
  assign word_sel = addr_i[2 +: WIDX_W];

  // bitmapped ownership and global control
  logic [NUM_PINS-1:0] owner_q;
  logic                line_sel_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_owner
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) owner_q[p] <= 1'b1;
      else if (wr_en_i && bm_hit && word_sel == WIDX_W'(p / 32))
        owner_q[p] <= wdata_i[p % 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_sel_q <= 1'b0;
    else if (wr_en_i && ctrl_hit) line_sel_q <= wdata_i[0];
  end

  // per-pin configuration
  logic [NUM_PINS-1:0] in_sync;
  logic [DATA_W-1:0]   cfg1_rd [NUM_PINS];
  logic [DATA_W-1:0]   cfg2_rd [NUM_PINS];

  gpio_in_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_i),
    .sync_o (in_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic     sel;
    pin_cfg_t cfg;
    assign sel = wr_en_i && cfg_hit && (pin_sel == PSEL_W'(p));

    gpio_pin_cfg i_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_c1_i  (sel && !addr_i[2]),
      .wr_c2_i  (sel && addr_i[2]),
      .wdata_i  (wdata_i),
      .in_sync_i(in_sync[p]),
      .cfg1_rd_o(cfg1_rd[p]),
      .cfg2_rd_o(cfg2_rd[p]),
      .cfg_o    (cfg),
      .sense_o  (sense_o[p])
    );

    assign gpio_o[p]         = cfg.out_lvl;
    assign gpio_oe_o[p]      = cfg.use_gpio & ~cfg.dir_in;
    assign use_gpio_o[p]     = cfg.use_gpio;
    assign sense_en_o[p]     = ~cfg.sense_dis;
    assign trig_level_o[p]   = cfg.trig_level;
    assign trig_inv_o[p]     = cfg.trig_inv;
    assign pull_o[2*p +: 2]  = cfg.pull;
  end

  assign owner_o        = owner_q;
  assign irq_line_sel_o = line_sel_q;

  // read path
  logic [NUM_WORDS*32-1:0] owner_pad;
  logic [DATA_W-1:0]       rd_mux;

  assign owner_pad = (NUM_WORDS*32)'(owner_q);

  always_comb begin
    rd_mux = '0;
    if (bm_hit)        rd_mux = owner_pad[32*word_sel +: 32];
    else if (ctrl_hit) rd_mux = DATA_W'(line_sel_q);
    else if (cfg_hit)  rd_mux = addr_i[2] ? cfg2_rd[pin_idx] : cfg1_rd[pin_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_PINS = 94,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pad_i,
  input logic [NUM_PINS-1:0] gpio_oe_o,
  input logic [NUM_PINS-1:0] use_gpio_o,
  input logic [NUM_PINS-1:0] sense_en_o,
  input logic [NUM_PINS-1:0] sense_o,
  input logic                irq_line_sel_o
);
  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(256 + 8 * NUM_PINS);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_oe_needs_gpio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_oe_o & ~use_gpio_o) == '0);

  p_sense_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_o & ~sense_en_o) == '0);

  p_sync_depth_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (sense_o == ($past(pad_i, 2) & sense_en_o)));

  p_line_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(12'h07C)) |=> (irq_line_sel_o == $past(wdata_i[0])));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i >= CFG_END) |=> (rdata_o == '0));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .pad_i         (pad_i),
  .gpio_oe_o     (gpio_oe_o),
  .use_gpio_o    (use_gpio_o),
  .sense_en_o    (sense_en_o),
  .sense_o       (sense_o),
  .irq_line_sel_o(irq_line_sel_o)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int N = 94;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  pad_i = '0;
  logic [N-1:0]  gpio_o, gpio_oe_o, owner_o, use_gpio_o, sense_en_o, sense_o;
  logic [N-1:0]  trig_level_o, trig_inv_o;
  logic [2*N-1:0] pull_o;
  logic          irq_line_sel_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_bank_regs i_gpio_bank_regs (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_en_i = 1'b0; d = rdata_o;
  endtask

  function automatic logic [11:0] c1(int p); return 12'(256 + 8 * p); endfunction
  function automatic logic [11:0] c2(int p); return 12'(260 + 8 * p); endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(c1(0), d);  chk("R1 cfg1 pin0", d, 32'h5);
    rd(c2(93), d); chk("R1 cfg2 pin93", d, 32'h4);
    rd(12'h000, d); chk("R1 owner w0", d, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R1 owner w2", d, 32'h3FFF_FFFF);
    rd(12'h07C, d); chk("R1 line sel", d, 32'h0);
    chk("R1 sense_en", 32'(sense_en_o[0]), 32'h0);
  endtask

  task automatic t_owner;
    logic [31:0] d;
    wr(12'h004, 32'hFFFF_FFFE);
    chk("R2 owner32", 32'(owner_o[32]), 32'h0);
    chk("R2 owner33", 32'(owner_o[33]), 32'h1);
    chk("R2 owner31", 32'(owner_o[31]), 32'h1);
    wr(12'h008, 32'hDFFF_FFFF);
    chk("R2 owner93", 32'(owner_o[93]), 32'h0);
    rd(12'h008, d); chk("R2 w2 readback", d, 32'h1FFF_FFFF);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(c1(47), 32'hFFFF_FFFF);
    rd(c1(47), d); chk("R3 cfg1 mask", d, 32'h8000_001D);
    wr(c2(47), 32'hFFFF_FFFF);
    rd(c2(47), d); chk("R3 cfg2 mask", d, 32'h7);
    rd(c1(46), d); chk("R3 neighbour untouched", d, 32'h5);
    rd(c1(48), d); chk("R3 neighbour untouched", d, 32'h5);
  endtask

  task automatic t_output;
    wr(c1(10), 32'h8000_0001);
    chk("R4 level", 32'(gpio_o[10]), 32'h1);
    chk("R4 oe gpio output", 32'(gpio_oe_o[10]), 32'h1);
    wr(c1(10), 32'h8000_0000);
    chk("R4 oe native", 32'(gpio_oe_o[10]), 32'h0);
    wr(c1(10), 32'h0000_0005);
    chk("R4 oe input", 32'(gpio_oe_o[10]), 32'h0);
    chk("R4 level low", 32'(gpio_o[10]), 32'h0);
  endtask

  task automatic t_input;
    logic [31:0] d;
    wr(c2(93), 32'h0);
    pad_i[93] = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(c1(93), d); chk("R5 bit30 high", d, 32'h4000_0005);
    wr(c1(93), 32'h0000_0005);
    rd(c1(93), d); chk("R5 bit30 write ignored", d, 32'h4000_0005);
    pad_i[93] = 1'b0;
    repeat (3) @(negedge clk_i);
    wr(c1(93), 32'h4000_0005);
    rd(c1(93), d); chk("R5 bit30 low", d, 32'h0000_0005);
  endtask

  task automatic t_sense_dis;
    logic [31:0] d;
    pad_i[20] = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R6 sense_o gated", 32'(sense_o[20]), 32'h0);
    rd(c1(20), d); chk("R6 bit30 gated", d, 32'h5);
    pad_i[20] = 1'b0;
  endtask

  task automatic t_sync;
    wr(c2(5), 32'h0);
    repeat (3) @(negedge clk_i);
    pad_i[5] = 1'b1;
    @(negedge clk_i); chk("R7 after 1 edge", 32'(sense_o[5]), 32'h0);
    @(negedge clk_i); chk("R7 after 2 edges", 32'(sense_o[5]), 32'h1);
    pad_i[5] = 1'b0;
    @(negedge clk_i); chk("R7 fall 1 edge", 32'(sense_o[5]), 32'h1);
    @(negedge clk_i); chk("R7 fall 2 edges", 32'(sense_o[5]), 32'h0);
  endtask

  task automatic t_export;
    wr(c1(0), 32'h0000_0011);
    chk("R8 level trig", 32'(trig_level_o[0]), 32'h1);
    chk("R8 inv", 32'(trig_inv_o[0]), 32'h0);
    wr(c1(0), 32'h0000_0008);
    chk("R8 edge inv", 32'({trig_level_o[0], trig_inv_o[0]}), 32'h1);
    chk("R8 use native", 32'(use_gpio_o[0]), 32'h0);
    wr(c2(63), 32'h2);
    chk("R8 pull", 32'(pull_o[127:126]), 32'h2);
    chk("R8 sense_en", 32'(sense_en_o[63]), 32'h1);
  endtask

  task automatic t_global;
    logic [31:0] d;
    wr(12'h07C, 32'hFFFF_FFFF);
    chk("R9 line 15", 32'(irq_line_sel_o), 32'h1);
    rd(12'h07C, d); chk("R9 readback", d, 32'h1);
    wr(12'h07C, 32'h0);
    chk("R9 line 14", 32'(irq_line_sel_o), 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(12'h00C, d); chk("R10 past bitmap", d, 32'h0);
    rd(12'h040, d); chk("R10 gap", d, 32'h0);
    wr(c1(94), 32'hFFFF_FFFF);
    rd(c1(94), d); chk("R10 pin 94", d, 32'h0);
    wr(12'h101, 32'h0);
    rd(c1(0), d); chk("R10 unaligned write", d, 32'h8);
    rd(12'h101, d); chk("R10 unaligned read", d, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    rd(12'h000, d);
    @(negedge clk_i); addr_i = c1(47);
    repeat (2) @(negedge clk_i);
    chk("R11 hold", rdata_o, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_owner();
    t_cfg();
    t_output();
    t_input();
    t_sense_dis();
    t_sync();
    t_export();
    t_global();
    t_unmapped();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule